// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor port and a word-wide main memory port. A 7-bit byte address is split into a 3-bit tag, a 2-bit set selector and a 2-bit byte offset. The offset is ignored because all accesses are whole 32-bit words. Each of the four sets holds two one-word lines, and each line carries a valid bit, a dirty bit, a tag and a data word. One recency bit per set chooses the line to replace.

The processor raises `cpuReq` with a command, an address and, for writes, data. It holds all of them until `cpuReady` is high at a clock edge. A hit completes in the cycle the request is presented. A miss stalls the processor while the cache does two things. First, if the chosen victim line is dirty, the cache writes it back to memory. Then it reads the missing word. Write misses allocate the line and merge the store data into it. Writes never go to memory directly; memory is updated only when a dirty line is evicted.

Top module: `tiny_wb_cache`

## Requirements
- R1: After reset, every line is invalid and no memory request is raised. The first access to any word is therefore a miss.
- R2: Address bits [3:2] select the set and bits [6:4] form the tag. Bits [1:0] have no effect on which word is accessed.
- R3: A read hit raises `cpuReady` in the cycle it is presented, with no memory transaction, and returns the latest value written to that word.
- R4: On a miss the victim is chosen as follows: an invalid way in the set (way 0 before way 1); if both ways are valid, the way not used most recently. Every hit and every fill marks the way it touched as most recent.
- R5: A write hit updates only the cached word and marks the line dirty. Memory is not written.
- R6: When a dirty victim is evicted, the cache first writes its word to the victim's own address (`memWe`=1). Only then does it read the new word. A clean victim causes no memory write.
- R7: A write miss reads the line from memory, replaces the word with the store data and leaves the line dirty.
- R8: After reset, reads of word addresses 0, 8, 0, 6, 8, 16 give miss, miss, hit, miss, hit, miss. The last access evicts word 0 from set 0.
- R9: While a miss is serviced, `cpuReady` stays low. A read miss completes in the cycle the fill acknowledge arrives, and `cpuRdata` then equals `memRdata`.
- R10: A memory request keeps `memReq`, `memWe` and `memAddr` stable until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuReq | input | 1 | Processor request, held until accepted |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 7 | Byte address |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid with cpuReady on a read |
| cpuReady | output | 1 | Request completes at this clock edge |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = writeback, 0 = fill read |
| memAddr | output | 7 | Word-aligned memory byte address |
| memWdata | output | 32 | Writeback data |
| memRdata | input | 32 | Fill data, valid with memAck |
| memAck | input | 1 | Memory completes the request this cycle |

## Verification
Two functions can meet in the same cycle. One is completing a processor read. The other is accepting the memory's fill acknowledge, because the stall is released by that acknowledge and the returned word is forwarded straight from `memRdata`. The bench provokes this on every read miss, both after clean and after dirty evictions. A long pseudo-random sweep over all 32 words does this many times. The bench then judges the loaded value against a flat shadow copy of memory kept by the bench, and it judges the hit/miss and writeback pattern against its own two-way recency model.

// File: rtl/tiny_wb_cache_pkg.sv
package tiny_wb_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } cacheState_t;

  typedef struct packed {
    logic hitAcc;   // processor access completes on a hit
    logic fill;     // fill word arrives this cycle
    logic selWb;    // memory address points at the victim
  } ctlStrobe_t;
endpackage

// File: rtl/tiny_wb_cache_dp.sv
module tiny_wb_cache_dp
  import tiny_wb_cache_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              hit,
  output logic              victimDirty
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int WAYS  = 2;

  logic [DATA_W-1:0] dataArr [SETS][WAYS];
  logic [TAG_W-1:0]  tagArr  [SETS][WAYS];
  logic              validArr[SETS][WAYS];
  logic              dirtyArr[SETS][WAYS];
  logic              lruBit  [SETS];

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  wayHit;
  logic             hitWay;
  logic             victimWay;
  logic [DATA_W-1:0] hitData;

  assign setIdx = cpuAddr[OFF_W +: IDX_W];
  assign reqTag = cpuAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validArr[setIdx][w] && (tagArr[setIdx][w] == reqTag);
  end

  assign hit     = |wayHit;
  assign hitWay  = wayHit[1];
  assign hitData = dataArr[setIdx][hitWay];

  always_comb begin
    if (!validArr[setIdx][0])      victimWay = 1'b0;
    else if (!validArr[setIdx][1]) victimWay = 1'b1;
    else                           victimWay = lruBit[setIdx];
  end

  assign victimDirty = validArr[setIdx][victimWay] && dirtyArr[setIdx][victimWay];
  assign memWdata    = dataArr[setIdx][victimWay];
  assign memAddr     = strobe.selWb
                     ? {tagArr[setIdx][victimWay], setIdx, {OFF_W{1'b0}}}
                     : {reqTag, setIdx, {OFF_W{1'b0}}};
  assign cpuRdata    = strobe.fill ? memRdata : hitData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lruBit[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) begin
          validArr[s][w] <= 1'b0;
          dirtyArr[s][w] <= 1'b0;
        end
      end
    end else if (strobe.fill) begin
      validArr[setIdx][victimWay] <= 1'b1;
      dirtyArr[setIdx][victimWay] <= cpuWe;
      tagArr[setIdx][victimWay]   <= reqTag;
      dataArr[setIdx][victimWay]  <= cpuWe ? cpuWdata : memRdata;
      lruBit[setIdx]              <= ~victimWay;
    end else if (strobe.hitAcc) begin
      lruBit[setIdx] <= ~hitWay;
      if (cpuWe) begin
        dataArr[setIdx][hitWay]  <= cpuWdata;
        dirtyArr[setIdx][hitWay] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tiny_wb_cache_ctl.sv
module tiny_wb_cache_ctl
  import tiny_wb_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       memAck,
  output ctlStrobe_t strobe,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe
);
  cacheState_t state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:  if (cpuReq && !hit) nextState = victimDirty ? ST_WBACK : ST_FILL;
      ST_WBACK: if (memAck) nextState = ST_FILL;
      ST_FILL:  if (memAck) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign strobe.hitAcc = (state == ST_IDLE) && cpuReq && hit;
  assign strobe.fill   = (state == ST_FILL) && memAck;
  assign strobe.selWb  = (state == ST_WBACK);
  assign memReq        = (state != ST_IDLE);
  assign memWe         = (state == ST_WBACK);
  assign cpuReady      = strobe.hitAcc || strobe.fill;
endmodule

// File: rtl/tiny_wb_cache.sv
module tiny_wb_cache
  import tiny_wb_cache_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);
  ctlStrobe_t strobe;
  logic       hit;
  logic       victimDirty;

  tiny_wb_cache_ctl ctl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .hit(hit),
    .victimDirty(victimDirty), .memAck(memAck), .strobe(strobe),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe)
  );

  tiny_wb_cache_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .memRdata(memRdata),
    .cpuRdata(cpuRdata), .memAddr(memAddr), .memWdata(memWdata),
    .hit(hit), .victimDirty(victimDirty)
  );
endmodule

// File: rtl/tiny_wb_cache_chk.sv
module tiny_wb_cache_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic [DATA_W-1:0] cpuRdata,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memRdata
);
  // R1: no memory activity right after reset is released
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $rose(rstN) |-> !memReq);

  // R3: a completing access never overlaps a writeback or an unacknowledged request
  p_ready_without_traffic_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> (!memReq || (memAck && !memWe)));

  // R6: an acknowledged writeback is always followed by a fill read
  p_fill_after_wb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (memReq && !memWe));

  // R9: processor stays stalled while memory is busy without acknowledge
  p_stall_while_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |-> !cpuReady);

  // R9: a read completed by a fill forwards the memory word
  p_fill_forward_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && cpuReq && !cpuWe && memReq) |-> (cpuRdata == memRdata));

  // R10: request fields hold until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));
endmodule

bind tiny_wb_cache tiny_wb_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
  .cpuReady(cpuReady), .cpuRdata(cpuRdata), .memReq(memReq),
  .memWe(memWe), .memAck(memAck), .memAddr(memAddr), .memRdata(memRdata)
);

// File: tb/tiny_wb_cache_tb_top.sv
module tiny_wb_cache_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [6:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuReady;
  logic        memReq;
  logic        memWe;
  logic [6:0]  memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  tiny_wb_cache dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model: ack after 2 request cycles ----------------
  logic [31:0] mem [32];
  int memCnt = 0;
  int nFills = 0;
  int nWbs   = 0;
  int lastWbWord = -1;

  function automatic logic [31:0] initWord(input int w);
    return 32'h1000_0000 + w * 32'h0001_0003;
  endfunction

  initial for (int i = 0; i < 32; i++) mem[i] = initWord(i);

  always @(negedge clk) begin
    if (memAck) begin
      memAck <= 1'b0;
      memCnt <= 0;
    end else if (memReq && rstN) begin
      if (memCnt == 1) begin
        memAck <= 1'b1;
        if (memWe) begin
          mem[memAddr[6:2]] <= memWdata;
          nWbs++;
          lastWbWord = int'(memAddr[6:2]);
        end else begin
          memRdata <= mem[memAddr[6:2]];
          nFills++;
        end
      end else memCnt <= memCnt + 1;
    end
  end

  // ---------------- reference model ----------------
  bit          rValid[4][2];
  bit          rDirty[4][2];
  logic [2:0]  rTag[4][2];
  bit          rLru[4];
  logic [31:0] shadow[32];
  bit          lastHit;
  int          lastStall;

  task automatic access(input bit we, input int w, input logic [31:0] wd, input logic [1:0] off);
    int set = w % 4;
    logic [2:0] tg = 3'(w / 4);
    int hw = -1;
    int v;
    bit expWb;
    int wbWord;
    int f0 = nFills, b0 = nWbs;
    bit done = 0;
    logic [31:0] rd = '0;
    int stall = 0;
    for (int k = 0; k < 2; k++) if (rValid[set][k] && rTag[set][k] == tg) hw = k;
    v = !rValid[set][0] ? 0 : (!rValid[set][1] ? 1 : int'(rLru[set]));
    expWb  = (hw < 0) && rValid[set][v] && rDirty[set][v];
    wbWord = int'(rTag[set][v]) * 4 + set;

    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAddr = {5'(w), off}; cpuWdata = wd;
    while (!done) begin
      #8;
      if (cpuReady) begin done = 1; rd = cpuRdata; end
      else begin stall++; @(negedge clk); end
    end
    @(negedge clk);
    cpuReq = 0;

    lastHit = (nFills == f0);
    lastStall = stall;
    check(lastHit == (hw >= 0), "R4 hit/miss vs recency model", lastHit, hw >= 0);
    check((nWbs - b0) == int'(expWb), "R6 writeback count", nWbs - b0, expWb);
    if (expWb) begin
      check(lastWbWord == wbWord, "R6 writeback address", lastWbWord, wbWord);
      check(mem[wbWord] == shadow[wbWord], "R6 writeback data", mem[wbWord], shadow[wbWord]);
    end
    if (!we) check(rd == shadow[w], "R3 R9 load data", rd, shadow[w]);
    if (hw >= 0) check(stall == 0, "R3 hit completes without stall", stall, 0);
    else         check(stall >= 2, "R9 miss stalls", stall, 2);

    if (we) shadow[w] = wd;
    if (hw >= 0) begin
      rLru[set] = (hw == 0);
      if (we) rDirty[set][hw] = 1;
    end else begin
      rValid[set][v] = 1; rTag[set][v] = tg; rDirty[set][v] = we;
      rLru[set] = (v == 0);
    end
  endtask

  initial begin
    #3_000_000;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    bit expPat[6];
    int tr[6];
    logic [31:0] lcg;
    for (int i = 0; i < 32; i++) shadow[i] = initWord(i);
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    check(cpuReady == 0 && memReq == 0, "R1 idle outputs in reset", {cpuReady, memReq}, 0);
    rstN = 1;
    @(negedge clk);
    check(memReq == 0, "R1 no request after reset", memReq, 0);

    // R8: reference trace
    tr = '{0, 8, 0, 6, 8, 16};
    expPat = '{0, 0, 1, 0, 1, 0};
    for (int i = 0; i < 6; i++) begin
      access(0, tr[i], '0, 2'b00);
      check(lastHit == expPat[i], "R8 trace hit/miss", lastHit, expPat[i]);
    end
    // R8: word 0 evicted by 16, word 8 still resident
    access(0, 8, '0, 2'b00);
    check(lastHit == 1, "R8 word 8 still resident", lastHit, 1);
    access(0, 0, '0, 2'b00);
    check(lastHit == 0, "R8 word 0 was evicted", lastHit, 0);

    // R2: byte offset ignored
    access(0, 0, '0, 2'b11);
    check(lastHit == 1, "R2 offset bits ignored", lastHit, 1);

    // R7: write miss allocates, memory untouched
    access(1, 5, 32'hCAFE_0005, 2'b00);
    check(lastHit == 0, "R7 write miss fetches", lastHit, 0);
    check(mem[5] == initWord(5), "R7 memory not written", mem[5], initWord(5));
    access(0, 5, '0, 2'b01);
    check(lastHit == 1, "R7 allocated line hits", lastHit, 1);

    // R5: write hit stays in cache
    access(1, 5, 32'hBEEF_0005, 2'b00);
    check(mem[5] == initWord(5), "R5 write hit leaves memory", mem[5], initWord(5));
    access(0, 5, '0, 2'b00);

    // R6: force dirty eviction of word 5 from set 1
    access(0, 9, '0, 2'b00);
    access(0, 13, '0, 2'b00);
    check(mem[5] == 32'hBEEF_0005, "R6 dirty word written back", mem[5], 32'hBEEF_0005);

    // near-exhaustive sweep
    lcg = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      access(lcg[20], int'(lcg[28:24]), lcg ^ 32'h5A5A_0000, lcg[11:10]);
    end
    // read back every word
    for (int w = 0; w < 32; w++) access(0, w, '0, 2'b00);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule